// File: doc/BRIEF.md
# Multicast Hash Filter and PHY-Presence Interrupt Register Bank

This block is a small slice of a network controller's register space. It stores a 64-bit multicast hash filter that the receive path uses to accept or drop group-addressed frames. Host software sees the filter as four 16-bit registers. The block also raises an interrupt when the PHY-presence signal changes level, and it holds an enable bit that masks that interrupt.

The host reaches the block through a plain register port with address, write data, a write strobe, a read strobe and combinational read data. While the controller runs, the filter is locked: writes and reads to it take effect only while the stopped or suspended mode input is high. The interrupt register is reachable at all times. A hard reset clears the interrupt flag and its enable. A soft reset leaves every register untouched, and so does raising the stop mode. The filter has no reset at all.

Top module: `hashfilt_csr_bank`

## Requirements
- R1: The filter register at address k (k = 0..3) holds filter bits [16k+15:16k] in data bits [15:0]. A write that is allowed shows on `hash_filter` after the clock edge that samples it.
- R2: Write data bits [31:16] to a filter register are discarded. A filter read returns zero in bits [31:16] and the stored 16 bits in bits [15:0].
- R3: When both `stop_mode` and `suspend_mode` are 0, a filter write leaves `hash_filter` unchanged and a filter read returns all zeros.
- R4: A hard reset, a soft reset, or raising `stop_mode` does not change `hash_filter`.
- R5: Every change of `phy_present`, rising or falling, sets the interrupt flag (bit 0 of the interrupt register at address 4). The flag becomes 1 on the third rising clock edge after the input changes, because the input goes through two synchronizer flops and an edge-detect flop.
- R6: A write to address 4 with data bit 0 equal to 1 clears the flag. A write with data bit 0 equal to 0 leaves the flag unchanged.
- R7: When an edge is detected in the same cycle as a clearing write, the flag stays 1.
- R8: A hard reset clears the flag and the enable (bit 1 of address 4). A soft reset or a change of `stop_mode` leaves both unchanged.
- R9: `irq_req` is 1 exactly when the flag and the enable are both 1.
- R10: Address 4 can be written and read whatever the values of `stop_mode` and `suspend_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous active-high hard reset |
| soft_rst | input | 1 | Soft reset; has no effect on this block's registers |
| stop_mode | input | 1 | Controller stopped |
| suspend_mode | input | 1 | Controller suspended |
| phy_present | input | 1 | Asynchronous PHY-presence level |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Combinational read data, zero when no read is valid |
| irq_req | output | 1 | Interrupt request |
| hash_filter | output | 64 | Current filter value |

## Verification
Filter traffic is random: writes and reads go to random lanes with random data, under random combinations of the stop and suspend inputs. Comparing `hash_filter` against a model after each operation separates allowed writes from locked ones, shows that the lane ordering is right, and shows that the upper halves are discarded. Rising and falling PHY edges are each timed to the exact edge on which the flag sets, which catches a wrong synchronizer depth. Write-0, write-1, and a clear that lands in the same cycle as an edge separate the clear rule from the set-wins priority. Soft reset, the stop input and hard reset are each applied on their own so that each reset's scope can be seen.

// File: rtl/hfcsr_pkg.sv
package hfcsr_pkg;

    parameter int DATA_W   = 32;
    parameter int LANE_W   = 16;
    parameter int LANES    = 4;
    parameter int ADDR_W   = 4;
    localparam int FILT_W  = LANES * LANE_W;

    // Address map of this bank
    parameter int FILT_BASE = 0;
    parameter int IRQ_ADDR  = 4;

    // Bit positions inside the interrupt register
    parameter int FLAG_BIT = 0;
    parameter int EN_BIT   = 1;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_FILT = 2'd1,
        TGT_IRQ  = 2'd2
    } tgt_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } host_req_t;

    function automatic tgt_e decode_target(input logic [ADDR_W-1:0] addr);
        if (int'(addr) >= FILT_BASE && int'(addr) < FILT_BASE + LANES)
            return TGT_FILT;
        else if (int'(addr) == IRQ_ADDR)
            return TGT_IRQ;
        else
            return TGT_NONE;
    endfunction

endpackage

// File: rtl/hfcsr_edge_sync.sv
module hfcsr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic edge_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    sync_q[g] <= 1'b0;
                else if (g == 0)
                    sync_q[g] <= din;
                else
                    sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= 1'b0;
        else
            last_q <= sync_q[STAGES-1];
    end

    assign edge_pulse = sync_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/hfcsr_filter_bank.sv
module hfcsr_filter_bank
    import hfcsr_pkg::*;
#(
    parameter int NLANES = LANES,
    parameter int LW     = LANE_W,
    parameter int AW     = ADDR_W,
    parameter int BASE   = FILT_BASE
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [LW-1:0]      wdata,
    output logic [LW-1:0]      rlane,
    output logic [NLANES*LW-1:0] filt
);
    localparam int SELW = (NLANES > 1) ? $clog2(NLANES) : 1;

    logic [LW-1:0] lane_q [NLANES];
    logic [SELW-1:0] sel;

    assign sel = SELW'(addr - AW'(BASE));

    genvar i;
    generate
        for (i = 0; i < NLANES; i++) begin : g_lane
            logic [LW-1:0] store_q = '0;
            always_ff @(posedge clk) begin
                if (wr_en && addr == AW'(BASE + i))
                    store_q <= wdata;
            end
            assign lane_q[i]             = store_q;
            assign filt[i*LW +: LW]      = store_q;
        end
    endgenerate

    always_comb begin
        rlane = '0;
        for (int k = 0; k < NLANES; k++)
            if (sel == SELW'(k))
                rlane = lane_q[k];
    end

endmodule

// File: rtl/hfcsr_irq_ctl.sv
module hfcsr_irq_ctl (
    input  logic clk,
    input  logic rst,
    input  logic edge_pulse,
    input  logic wr_hit,
    input  logic clr_bit,
    input  logic en_bit,
    output logic flag_q,
    output logic en_q,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (edge_pulse)
            flag_q <= 1'b1;
        else if (wr_hit && clr_bit)
            flag_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (wr_hit)
            en_q <= en_bit;
    end

    assign irq = flag_q & en_q;

endmodule

// File: rtl/hashfilt_csr_bank.sv
module hashfilt_csr_bank
    import hfcsr_pkg::*;
(
    input  logic              clk,
    input  logic              hard_rst,
    input  logic              soft_rst,
    input  logic              stop_mode,
    input  logic              suspend_mode,
    input  logic              phy_present,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req,
    output logic [FILT_W-1:0] hash_filter
);
    host_req_t     req;
    tgt_e          tgt;
    logic          filt_open;
    logic          filt_wr;
    logic          irq_wr;
    logic          clr_req;
    logic          edge_seen;
    logic          flag_q;
    logic          en_q;
    logic [LANE_W-1:0] rd_lane;
    logic          unused_soft_rst;

    // Soft reset does not reach any register held here.
    assign unused_soft_rst = soft_rst;

    assign req = '{wr: reg_wr, rd: reg_rd, addr: reg_addr, data: reg_wdata};
    assign tgt = decode_target(req.addr);

    assign filt_open = stop_mode | suspend_mode;
    assign filt_wr   = req.wr && filt_open && (tgt == TGT_FILT);
    assign irq_wr    = req.wr && (tgt == TGT_IRQ);
    assign clr_req   = irq_wr && req.data[FLAG_BIT];

    hfcsr_edge_sync #(.STAGES(2)) u_sync (
        .clk        (clk),
        .rst        (hard_rst),
        .din        (phy_present),
        .edge_pulse (edge_seen)
    );

    hfcsr_filter_bank #(
        .NLANES (LANES),
        .LW     (LANE_W),
        .AW     (ADDR_W),
        .BASE   (FILT_BASE)
    ) u_filt (
        .clk   (clk),
        .wr_en (filt_wr),
        .addr  (req.addr),
        .wdata (req.data[LANE_W-1:0]),
        .rlane (rd_lane),
        .filt  (hash_filter)
    );

    hfcsr_irq_ctl u_irq (
        .clk        (clk),
        .rst        (hard_rst),
        .edge_pulse (edge_seen),
        .wr_hit     (irq_wr),
        .clr_bit    (req.data[FLAG_BIT]),
        .en_bit     (req.data[EN_BIT]),
        .flag_q     (flag_q),
        .en_q       (en_q),
        .irq        (irq_req)
    );

    always_comb begin
        reg_rdata = '0;
        if (req.rd) begin
            unique case (tgt)
                TGT_FILT: if (filt_open) reg_rdata[LANE_W-1:0] = rd_lane;
                TGT_IRQ: begin
                    reg_rdata[FLAG_BIT] = flag_q;
                    reg_rdata[EN_BIT]   = en_q;
                end
                default: reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/hfcsr_checker.sv
module hfcsr_checker
    import hfcsr_pkg::*;
(
    input logic              clk,
    input logic              hard_rst,
    input logic              filt_open,
    input logic              filt_wr,
    input logic              edge_seen,
    input logic              clr_req,
    input logic              flag_q,
    input logic              en_q,
    input logic              irq_req,
    input logic [FILT_W-1:0] hash_filter
);
    // R3: a locked filter cannot change on the following edge
    p_filter_locked_r3: assert property (@(posedge clk) disable iff (hard_rst)
        !filt_open |=> $stable(hash_filter));

    // R4: only an allowed filter write moves the filter, resets included
    p_filter_only_by_write_r4: assert property (@(posedge clk)
        !filt_wr |=> $stable(hash_filter));

    // R5 / R7: a detected edge leaves the flag set, even against a clear
    p_edge_sets_flag_r5: assert property (@(posedge clk) disable iff (hard_rst)
        edge_seen |=> flag_q);

    // R6: a clearing write with no edge drops the flag
    p_w1c_clears_r6: assert property (@(posedge clk) disable iff (hard_rst)
        (clr_req && !edge_seen) |=> !flag_q);

    // R6: without a clearing write the flag cannot fall
    p_flag_holds_r6: assert property (@(posedge clk) disable iff (hard_rst)
        (flag_q && !clr_req) |=> flag_q);

    // R8: hard reset empties flag and enable
    p_hard_reset_clears_r8: assert property (@(posedge clk)
        hard_rst |=> (!flag_q && !en_q && !irq_req));

    // R9: a request never appears with the enable clear
    p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (hard_rst)
        irq_req |-> (en_q && flag_q));

endmodule

bind hashfilt_csr_bank hfcsr_checker u_hfcsr_checker (
    .clk         (clk),
    .hard_rst    (hard_rst),
    .filt_open   (filt_open),
    .filt_wr     (filt_wr),
    .edge_seen   (edge_seen),
    .clr_req     (clr_req),
    .flag_q      (flag_q),
    .en_q        (en_q),
    .irq_req     (irq_req),
    .hash_filter (hash_filter)
);

// File: tb/hashfilt_csr_bank_bench.sv
module hashfilt_csr_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int IRQ_A      = 4;

    logic        clk = 1'b0;
    logic        hard_rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        stop_mode = 1'b0;
    logic        suspend_mode = 1'b0;
    logic        phy_present = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [63:0] hash_filter;

    int checks = 0;
    int failures = 0;
    logic [63:0] exp_filt = '0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    hashfilt_csr_bank u_hashfilt_csr_bank (
        .clk          (clk),
        .hard_rst     (hard_rst),
        .soft_rst     (soft_rst),
        .stop_mode    (stop_mode),
        .suspend_mode (suspend_mode),
        .phy_present  (phy_present),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_rdata    (reg_rdata),
        .irq_req      (irq_req),
        .hash_filter  (hash_filter)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1;
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    function automatic logic [63:0] put_lane(input logic [63:0] f, input int k, input logic [31:0] d);
        logic [63:0] r = f;
        r[k*16 +: 16] = d[15:0];
        return r;
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        hard_rst = 1'b0;
        @(negedge clk);

        // Reset state
        check("R9 reset irq", irq_req, 0);
        rd_reg(IRQ_A, rv); check("R8 reset irq reg", rv, 0);

        // R1 / R2: load all lanes while stopped, junk in upper halves
        stop_mode = 1'b1;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] d;
            d = {16'hFFFF - 16'(k), 16'h1111 * 16'(k + 1)};
            wr_reg(4'(k), d);
            exp_filt = put_lane(exp_filt, k, d);
        end
        check("R1 lane order", hash_filter, exp_filt);
        check("R1 literal", hash_filter, 64'h4444_3333_2222_1111);
        rd_reg(4'd2, rv); check("R2 read upper zero", rv, 32'h0000_3333);

        // R3: locked
        stop_mode = 1'b0;
        wr_reg(4'd1, 32'h0000_ABCD);
        check("R3 locked write", hash_filter, exp_filt);
        rd_reg(4'd1, rv); check("R3 locked read", rv, 0);
        suspend_mode = 1'b1;
        wr_reg(4'd1, 32'h5555_ABCD);
        exp_filt = put_lane(exp_filt, 1, 32'h0000_ABCD);
        check("R1 suspend write", hash_filter, exp_filt);
        suspend_mode = 1'b0;

        // R5: rising edge timing
        @(negedge clk); phy_present = 1'b1;
        @(negedge clk);
        @(negedge clk); rd_reg(IRQ_A, rv); check("R5 not yet set", rv, 0);
        @(negedge clk); rd_reg(IRQ_A, rv); check("R5 rise sets flag", rv, 1);
        check("R9 masked", irq_req, 0);

        // R6
        wr_reg(IRQ_A, 32'h0); rd_reg(IRQ_A, rv); check("R6 write0 keeps", rv, 1);
        wr_reg(IRQ_A, 32'h1); rd_reg(IRQ_A, rv); check("R6 write1 clears", rv, 0);

        // R5: falling edge
        @(negedge clk); phy_present = 1'b0;
        repeat (3) @(negedge clk);
        rd_reg(IRQ_A, rv); check("R5 fall sets flag", rv, 1);

        // R7: clear collides with edge
        @(negedge clk); phy_present = 1'b1;
        @(negedge clk);
        wr_reg(IRQ_A, 32'h1);
        rd_reg(IRQ_A, rv); check("R7 set wins", rv, 1);

        // R9 / R10 with filter locked
        wr_reg(IRQ_A, 32'h2);
        check("R9 irq on", irq_req, 1);
        wr_reg(IRQ_A, 32'h3);
        check("R9 irq off after clear", irq_req, 0);
        rd_reg(IRQ_A, rv); check("R10 access while running", rv, 2);

        // R8 / R4: soft reset and stop leave state
        @(negedge clk); phy_present = 1'b0;
        repeat (3) @(negedge clk);
        soft_rst = 1'b1; repeat (2) @(negedge clk); soft_rst = 1'b0;
        stop_mode = 1'b1; @(negedge clk); stop_mode = 1'b0; @(negedge clk);
        rd_reg(IRQ_A, rv); check("R8 soft reset and stop keep", rv, 3);
        check("R4 soft reset and stop keep filter", hash_filter, exp_filt);
        hard_rst = 1'b1; repeat (2) @(negedge clk); hard_rst = 1'b0;
        @(negedge clk);
        rd_reg(IRQ_A, rv); check("R8 hard reset clears", rv, 0);
        check("R9 hard reset irq", irq_req, 0);
        check("R4 hard reset keeps filter", hash_filter, exp_filt);

        // Random filter traffic (R1, R2, R3)
        for (int n = 0; n < 400; n++) begin
            int k;
            logic [31:0] d;
            logic open;
            stop_mode    = ($urandom % 3) == 0;
            suspend_mode = ($urandom % 3) == 0;
            open = stop_mode | suspend_mode;
            k = int'($urandom % 4);
            d = $urandom;
            if ($urandom % 2) begin
                wr_reg(4'(k), d);
                if (open) exp_filt = put_lane(exp_filt, k, d);
                check(open ? "R1 random write" : "R3 random locked write", hash_filter, exp_filt);
            end else begin
                @(negedge clk);
                rd_reg(4'(k), rv);
                check(open ? "R2 random read" : "R3 random locked read", rv,
                      open ? {16'h0, exp_filt[k*16 +: 16]} : 64'h0);
            end
        end
        stop_mode = 1'b0; suspend_mode = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule